// File: doc/BRIEF.md
# Status-Driven I2C Message Sequencer

This block runs one I2C master message without host software in the loop. It sits beside a bus engine that reports progress as 8-bit status codes. The host loads a message descriptor with a single pulse. The descriptor holds a 7- or 10-bit target address, a direction, a byte count, and flags that mark the message as first, last or start-less. From then on the sequencer answers every status code from the engine with one action: start, restart, first or second address byte, write data, read data, read the final data and stop, continue, or stop. It also drives the acknowledge enable and interrupt enable bits of the engine.

The sequencer counts the bytes left and tracks the byte index. Write bytes come from a host-side buffer through `tx_idx`/`tx_byte`. Read bytes go back to the host on `rx_valid`/`rx_data`. A message ends with a one-cycle `done` pulse and a 2-bit result code. An external timeout input first asks for a graceful abort. If it fires a second time while the message is still running, the sequencer forces itself idle and resets the engine.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset, `busy`, `act_valid`, `done`, `rx_valid`, `eng_rst`, `ack_en` and `int_en` are 0 and `err` is 0.
- R2: `act_code` uses this encoding: continue=0, start=1, restart=2, address1=3, address2=4, write=5, read=6, read-final-and-stop=7, stop=8. Each action appears for exactly one cycle with `act_valid`, one cycle after the cycle that causes it. Accepting a message raises `busy`, `ack_en` and `int_en` and clears `err`. The first message issues start. A later message issues address1 directly.
- R3: The first address byte is {addr[6:0],rd} for a 7-bit address and {5'b11110,addr[9:8],rd} for a 10-bit address. The second address byte is addr[7:0]. Address actions carry these bytes on `act_byte`.
- R4: Status 0x08 or 0x10 from a busy state issues address1.
- R5: For a 10-bit message, status 0x18 or 0x40 issues address2.
- R6: Status 0x18 (7-bit), 0xD0 or 0x28 issues a write of buffer byte `tx_idx` while bytes remain. When none remain, it issues stop for a last message and restart otherwise. In both cases `done` pulses and `int_en` falls.
- R7: Status 0x40 (7-bit) or 0xE0 issues continue, or stop at once for a zero-length read. Status 0x50 issues read and presents `rx_byte` on `rx_data`. `ack_en` falls once exactly one byte remains to be received.
- R8: Status 0x58 issues read-final-and-stop, presents the byte, and pulses `done` with `err`=0 (unless an earlier error was recorded).
- R9: Status 0x20, 0x30 or 0x48 issues stop and ends the message with `err`=1 (no device).
- R10: Any other status while busy issues stop, pulses `eng_rst`, and ends with `err`=2 (I/O error).
- R11: A status arriving while the state is idle issues stop only, with no `done` and no `eng_rst`.
- R12: A first timeout while busy sets `err`=3 and emits no action. A write then stops at the next acknowledge once at least one data byte has gone out. A read drops `ack_en` at the next step.
- R13: A second timeout while still busy issues no action, pulses `done` and `eng_rst`, and clears `busy`.
- R14: A start-less read issues continue. A start-less write issues a write of buffer byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_go | input | 1 | Accept descriptor (ignored while busy) |
| msg_addr | input | 10 | Target address |
| msg_ten | input | 1 | 10-bit address mode |
| msg_rd | input | 1 | Read direction |
| msg_len | input | LEN_W | Byte count |
| msg_first | input | 1 | First message of a transfer |
| msg_last | input | 1 | Last message of a transfer |
| msg_nostart | input | 1 | Skip start and address phases |
| tx_byte | input | 8 | Buffer byte at `tx_idx` |
| st_valid | input | 1 | Engine reports a status code |
| st_code | input | 8 | Status code |
| rx_byte | input | 8 | Engine received-data register |
| timeout | input | 1 | Timeout expiry pulse |
| tx_idx | output | LEN_W | Buffer index for the next write byte |
| busy | output | 1 | Message in progress |
| act_valid | output | 1 | Action strobe |
| act_code | output | 4 | Action code |
| act_byte | output | 8 | Byte to load for address/write actions |
| ack_en | output | 1 | Acknowledge enable to engine |
| int_en | output | 1 | Interrupt enable to engine |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| eng_rst | output | 1 | Engine reset pulse |
| done | output | 1 | Message completion pulse |
| err | output | 2 | Result: 0 ok, 1 no device, 2 I/O, 3 timeout |

## Verification
The hardest situation to reach is the abort path. A timeout must land mid-message, after a data byte has already been issued, so that the byte-position condition decides between one more write and an immediate stop. The read-side abort must drop acknowledge before the count alone would. The stimulus places timeout pulses between status reports at chosen byte positions. A second pair of back-to-back timeouts drives the forced-idle path. Every emitted action is compared in order against a queue filled by the driver tasks.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  typedef enum logic [3:0] {
    A_CONT     = 4'd0,
    A_START    = 4'd1,
    A_RESTART  = 4'd2,
    A_ADDR1    = 4'd3,
    A_ADDR2    = 4'd4,
    A_WRITE    = 4'd5,
    A_READ     = 4'd6,
    A_READ_END = 4'd7,
    A_STOP     = 4'd8
  } act_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WSTART, S_WRESTART, S_WA1, S_WA2, S_WACK, S_WDATA
  } seq_st_e;

  localparam logic [7:0] SC_START     = 8'h08;
  localparam logic [7:0] SC_RESTART   = 8'h10;
  localparam logic [7:0] SC_WA_ACK    = 8'h18;
  localparam logic [7:0] SC_WA_NACK   = 8'h20;
  localparam logic [7:0] SC_WD_ACK    = 8'h28;
  localparam logic [7:0] SC_WD_NACK   = 8'h30;
  localparam logic [7:0] SC_RA_ACK    = 8'h40;
  localparam logic [7:0] SC_RA_NACK   = 8'h48;
  localparam logic [7:0] SC_RD_ACK    = 8'h50;
  localparam logic [7:0] SC_RD_NACK   = 8'h58;
  localparam logic [7:0] SC_WA2_ACK   = 8'hD0;
  localparam logic [7:0] SC_RA2_ACK   = 8'hE0;

  localparam logic [1:0] ERR_OK    = 2'd0;
  localparam logic [1:0] ERR_NODEV = 2'd1;
  localparam logic [1:0] ERR_IO    = 2'd2;
  localparam logic [1:0] ERR_TMO   = 2'd3;

  function automatic logic [7:0] addr_byte1(logic [9:0] a, logic ten, logic rd);
    if (ten) return {5'b11110, a[9:8], rd};
    return {a[6:0], rd};
  endfunction

  function automatic logic [7:0] addr_byte2(logic [9:0] a);
    return a[7:0];
  endfunction

  function automatic logic ends_msg(act_e a);
    return (a == A_STOP) || (a == A_RESTART) || (a == A_READ_END);
  endfunction

endpackage

// File: rtl/mseq_addr.sv
module mseq_addr
  import mseq_pkg::*;
(
  input  logic [9:0] addr,
  input  logic       ten,
  input  logic       rd,
  output logic [7:0] b1,
  output logic [7:0] b2
);
  assign b1 = addr_byte1(addr, ten, rd);
  assign b2 = addr_byte2(addr);
endmodule

// File: rtl/mseq_cnt.sv
module mseq_cnt #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] len,
  input  logic          step,
  output logic [LW-1:0] left,
  output logic [LW-1:0] pos
);
  logic [LW-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left  <= '0;
      pos   <= '0;
      len_q <= '0;
    end else if (load) begin
      len_q <= len;
      left  <= step ? len - LW'(1) : len;
      pos   <= step ? LW'(1) : '0;
    end else if (step && left != '0) begin
      left <= left - LW'(1);
      pos  <= pos + LW'(1);
    end
  end

  AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, left} + {1'b0, pos}) == {1'b0, len_q}); // R6
endmodule

// File: rtl/mseq_ctl.sv
module mseq_ctl
  import mseq_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          m_ten,
  input  logic          m_rd,
  input  logic          m_first,
  input  logic          m_last,
  input  logic          m_nos,
  input  logic [7:0]    b1_in,
  input  logic [7:0]    b2_in,
  input  logic [7:0]    tx_byte,
  input  logic          st_valid,
  input  logic [7:0]    st_code,
  input  logic [7:0]    rx_byte,
  input  logic          timeout,
  input  logic [LW-1:0] left,
  input  logic [LW-1:0] pos,
  output logic          load,
  output logic          step,
  output logic          busy,
  output logic          act_valid,
  output logic [3:0]    act_code,
  output logic [7:0]    act_byte,
  output logic          ack_en,
  output logic          int_en,
  output logic          rx_valid,
  output logic [7:0]    rx_data,
  output logic          eng_rst,
  output logic          done,
  output logic [1:0]    err
);
  seq_st_e    state, n_state;
  logic       abort_q, ten_q, last_q;
  logic [7:0] a1_q, a2_q;

  // named internal events
  logic       go_ok, tmo_soft, tmo_hard, wr_finish;
  logic       av, take, fin, erst, eset, aclr;
  act_e       ac;
  logic [7:0] ab;
  logic [1:0] eval;

  assign go_ok     = go && !busy;
  assign tmo_soft  = timeout && busy && !abort_q && !go;
  assign tmo_hard  = timeout && busy && abort_q && !go;
  assign wr_finish = (left == '0) || (abort_q && pos != '0);
  assign load      = go_ok;

  always_comb begin
    n_state = state; av = 1'b0; ac = A_CONT; ab = 8'h00; step = 1'b0;
    take = 1'b0; fin = 1'b0; erst = 1'b0; eset = 1'b0; eval = ERR_OK; aclr = 1'b0;
    if (go_ok) begin
      av = 1'b1;
      if (m_nos) begin
        if (m_rd) begin ac = A_CONT; n_state = S_WDATA; end
        else begin ac = A_WRITE; ab = tx_byte; step = 1'b1; n_state = S_WACK; end
      end else if (m_first) begin
        ac = A_START; n_state = S_WSTART;
      end else begin
        ac = A_ADDR1; ab = b1_in; n_state = S_WA1;
      end
    end else if (tmo_hard) begin
      n_state = S_IDLE; fin = 1'b1; erst = 1'b1;
    end else if (st_valid) begin
      av = 1'b1;
      if (state == S_IDLE) begin
        ac = A_STOP;
      end else begin
        case (st_code)
          SC_START, SC_RESTART: begin
            ac = A_ADDR1; ab = a1_q; n_state = S_WA1;
          end
          SC_WA_ACK, SC_WA2_ACK, SC_WD_ACK: begin
            if (st_code == SC_WA_ACK && ten_q) begin
              ac = A_ADDR2; ab = a2_q; n_state = S_WA2;
            end else if (wr_finish) begin
              ac = last_q ? A_STOP : A_RESTART;
              n_state = last_q ? S_IDLE : S_WRESTART;
              fin = busy;
            end else begin
              ac = A_WRITE; ab = tx_byte; step = 1'b1; n_state = S_WACK;
            end
          end
          SC_RA_ACK, SC_RA2_ACK: begin
            if (st_code == SC_RA_ACK && ten_q) begin
              ac = A_ADDR2; ab = a2_q; n_state = S_WA2;
            end else if (left == '0) begin
              ac = A_STOP; n_state = S_IDLE; fin = busy;
            end else begin
              ac = A_CONT; n_state = S_WDATA;
              aclr = (left == LW'(1)) || abort_q;
            end
          end
          SC_RD_ACK: begin
            ac = A_READ; take = 1'b1; step = 1'b1; n_state = S_WDATA;
            aclr = (left == LW'(2)) || abort_q;
          end
          SC_RD_NACK: begin
            ac = A_READ_END; take = 1'b1; step = 1'b1; n_state = S_IDLE; fin = busy;
          end
          SC_WA_NACK, SC_WD_NACK, SC_RA_NACK: begin
            ac = A_STOP; n_state = S_IDLE; fin = busy; eset = 1'b1; eval = ERR_NODEV;
          end
          default: begin
            ac = A_STOP; n_state = S_IDLE; fin = busy; erst = 1'b1;
            eset = 1'b1; eval = ERR_IO;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; busy <= 1'b0; abort_q <= 1'b0; ten_q <= 1'b0; last_q <= 1'b0;
      a1_q <= '0; a2_q <= '0; ack_en <= 1'b0; int_en <= 1'b0; err <= ERR_OK;
      act_valid <= 1'b0; act_code <= 4'd0; act_byte <= '0;
      rx_valid <= 1'b0; rx_data <= '0; eng_rst <= 1'b0; done <= 1'b0;
    end else begin
      state     <= n_state;
      act_valid <= av;
      act_code  <= ac;
      act_byte  <= ab;
      rx_valid  <= take;
      if (take) rx_data <= rx_byte;
      eng_rst   <= erst;
      done      <= fin;
      if (go_ok) begin
        busy <= 1'b1; abort_q <= 1'b0; err <= ERR_OK; ack_en <= 1'b1; int_en <= 1'b1;
        ten_q <= m_ten; last_q <= m_last; a1_q <= b1_in; a2_q <= b2_in;
      end else begin
        if (tmo_soft) begin abort_q <= 1'b1; err <= ERR_TMO; end
        if (eset) err <= eval;
        if (aclr) ack_en <= 1'b0;
        if (fin) busy <= 1'b0;
        if ((av && ends_msg(ac)) || tmo_hard) int_en <= 1'b0;
      end
    end
  end

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!int_en && !busy)); // R6
  AST_RX_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (act_valid && (act_code == A_READ || act_code == A_READ_END))); // R8
  AST_NODEV_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == ERR_NODEV) |-> (act_valid && act_code == A_STOP)); // R9
  AST_IO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rst && act_valid) |-> (act_code == A_STOP && err == ERR_IO)); // R10
  AST_FORCED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rst && !act_valid) |-> (done && err == ERR_TMO)); // R13
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_soft && !st_valid) |=> !act_valid); // R12
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
  import mseq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_go,
  input  logic [9:0]       msg_addr,
  input  logic             msg_ten,
  input  logic             msg_rd,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             msg_first,
  input  logic             msg_last,
  input  logic             msg_nostart,
  input  logic [7:0]       tx_byte,
  input  logic             st_valid,
  input  logic [7:0]       st_code,
  input  logic [7:0]       rx_byte,
  input  logic             timeout,
  output logic [LEN_W-1:0] tx_idx,
  output logic             busy,
  output logic             act_valid,
  output logic [3:0]       act_code,
  output logic [7:0]       act_byte,
  output logic             ack_en,
  output logic             int_en,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             eng_rst,
  output logic             done,
  output logic [1:0]       err
);
  logic [7:0]       b1, b2;
  logic [LEN_W-1:0] left, pos;
  logic             load, step;

  // a newly accepted message writes from index 0
  assign tx_idx = load ? '0 : pos;

  mseq_addr u_addr (
    .addr(msg_addr), .ten(msg_ten), .rd(msg_rd), .b1(b1), .b2(b2)
  );

  mseq_cnt #(.LW(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .len(msg_len), .step(step),
    .left(left), .pos(pos)
  );

  mseq_ctl #(.LW(LEN_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .go(msg_go), .m_ten(msg_ten), .m_rd(msg_rd),
    .m_first(msg_first), .m_last(msg_last), .m_nos(msg_nostart),
    .b1_in(b1), .b2_in(b2), .tx_byte(tx_byte), .st_valid(st_valid),
    .st_code(st_code), .rx_byte(rx_byte), .timeout(timeout),
    .left(left), .pos(pos), .load(load), .step(step), .busy(busy),
    .act_valid(act_valid), .act_code(act_code), .act_byte(act_byte),
    .ack_en(ack_en), .int_en(int_en), .rx_valid(rx_valid), .rx_data(rx_data),
    .eng_rst(eng_rst), .done(done), .err(err)
  );
endmodule

// File: tb/tb_i2c_msg_seq.sv
`timescale 1ns/1ps
module tb_i2c_msg_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       msg_go = 0, msg_ten = 0, msg_rd = 0, msg_first = 0, msg_last = 0, msg_nostart = 0;
  logic [9:0] msg_addr = '0;
  logic [7:0] msg_len = '0;
  logic [7:0] tx_byte;
  logic       st_valid = 0, timeout = 0;
  logic [7:0] st_code = '0, rx_byte = '0;
  logic [7:0] tx_idx;
  logic       busy, act_valid, ack_en, int_en, rx_valid, eng_rst, done;
  logic [3:0] act_code;
  logic [7:0] act_byte, rx_data;
  logic [1:0] err;
  logic [7:0] txm [0:7];

  assign tx_byte = txm[tx_idx[2:0]];

  i2c_msg_seq dut (
    .clk(clk), .rst_n(rst_n), .msg_go(msg_go), .msg_addr(msg_addr), .msg_ten(msg_ten),
    .msg_rd(msg_rd), .msg_len(msg_len), .msg_first(msg_first), .msg_last(msg_last),
    .msg_nostart(msg_nostart), .tx_byte(tx_byte), .st_valid(st_valid), .st_code(st_code),
    .rx_byte(rx_byte), .timeout(timeout), .tx_idx(tx_idx), .busy(busy),
    .act_valid(act_valid), .act_code(act_code), .act_byte(act_byte), .ack_en(ack_en),
    .int_en(int_en), .rx_valid(rx_valid), .rx_data(rx_data), .eng_rst(eng_rst),
    .done(done), .err(err)
  );

  int checks = 0, errors = 0;
  logic [12:0] expq[$];
  string       tagq[$];
  bit          finished = 0;

  localparam logic [3:0] C_CONT = 0, C_START = 1, C_RESTART = 2, C_ADDR1 = 3, C_ADDR2 = 4,
                         C_WRITE = 5, C_READ = 6, C_READ_END = 7, C_STOP = 8;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_act(string tag, logic [3:0] code, logic chkb, logic [7:0] b);
    expq.push_back({chkb, code, b});
    tagq.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && act_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R2: actual action %0d expected none", act_code);
      end else begin
        logic [12:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if (act_code !== e[11:8] || (e[12] && act_byte !== e[7:0])) begin
          errors++;
          $display("FAIL %s: actual %0d/%0h expected %0d/%0h", t, act_code, act_byte, e[11:8], e[7:0]);
        end
      end
    end
  end

  task automatic go(logic [9:0] a, logic ten, logic rd, logic [7:0] len,
                    logic first, logic last, logic nos);
    @(negedge clk);
    msg_addr = a; msg_ten = ten; msg_rd = rd; msg_len = len;
    msg_first = first; msg_last = last; msg_nostart = nos; msg_go = 1;
    @(negedge clk);
    msg_go = 0;
  endtask

  task automatic stat(logic [7:0] c, logic [7:0] rb);
    @(negedge clk);
    st_valid = 1; st_code = c; rx_byte = rb;
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic tmo();
    @(negedge clk);
    timeout = 1;
    @(negedge clk);
    timeout = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 4);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) txm[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {busy, act_valid, done, rx_valid, eng_rst, ack_en, int_en, err}, 16'h0);

    // 7-bit write, first and last: R2 R4 R3 R6
    txm[0] = 8'hA5; txm[1] = 8'h3C;
    expect_act("R2", C_START, 0, 0);
    go(10'h02A, 0, 0, 2, 1, 1, 0);
    chk("R2", {busy, ack_en, int_en, err}, {1'b1, 1'b1, 1'b1, 2'd0});
    expect_act("R4", C_ADDR1, 1, 8'h54); stat(8'h08, 0);
    expect_act("R6", C_WRITE, 1, 8'hA5); stat(8'h18, 0);
    expect_act("R6", C_WRITE, 1, 8'h3C); stat(8'h28, 0);
    expect_act("R6", C_STOP, 0, 0);      stat(8'h28, 0);
    chk("R6", {done, busy, int_en, err}, {1'b1, 1'b0, 1'b0, 2'd0});

    // 10-bit write, not last: R3 R5 R6 restart
    txm[0] = 8'h11;
    expect_act("R2", C_START, 0, 0);
    go(10'h2B5, 1, 0, 1, 1, 0, 0);
    expect_act("R3", C_ADDR1, 1, 8'hF4); stat(8'h08, 0);
    expect_act("R5", C_ADDR2, 1, 8'hB5); stat(8'h18, 0);
    expect_act("R6", C_WRITE, 1, 8'h11); stat(8'hD0, 0);
    expect_act("R6", C_RESTART, 0, 0);   stat(8'h28, 0);
    chk("R6", {done, int_en, err}, {1'b1, 1'b0, 2'd0});

    // 7-bit read, not first: R2 R7 R8
    expect_act("R2", C_ADDR1, 1, 8'hA1);
    go(10'h050, 0, 1, 3, 0, 1, 0);
    expect_act("R4", C_ADDR1, 1, 8'hA1); stat(8'h10, 0);
    expect_act("R7", C_CONT, 0, 0);      stat(8'h40, 0);
    chk("R7", {7'd0, ack_en}, 16'h1);
    expect_act("R7", C_READ, 0, 0);      stat(8'h50, 8'h01);
    chk("R7", {rx_valid, ack_en, rx_data}, {1'b1, 1'b1, 8'h01});
    expect_act("R7", C_READ, 0, 0);      stat(8'h50, 8'h02);
    chk("R7", {rx_valid, ack_en, rx_data}, {1'b1, 1'b0, 8'h02});
    expect_act("R8", C_READ_END, 0, 0);  stat(8'h58, 8'h03);
    chk("R8", {rx_valid, done, rx_data, 4'd0, err}, {1'b1, 1'b1, 8'h03, 4'd0, 2'd0});

    // zero-length read: R7
    expect_act("R2", C_START, 0, 0);
    go(10'h010, 0, 1, 0, 1, 1, 0);
    expect_act("R3", C_ADDR1, 1, 8'h21); stat(8'h08, 0);
    expect_act("R7", C_STOP, 0, 0);      stat(8'h40, 0);
    chk("R7", {done, busy, err}, {1'b1, 1'b0, 2'd0});

    // no device: R9
    expect_act("R2", C_START, 0, 0);
    go(10'h033, 0, 0, 1, 1, 1, 0);
    expect_act("R4", C_ADDR1, 1, 8'h66); stat(8'h08, 0);
    expect_act("R9", C_STOP, 0, 0);      stat(8'h20, 0);
    chk("R9", {done, eng_rst, err}, {1'b1, 1'b0, 2'd1});

    // unexpected code: R10
    expect_act("R2", C_START, 0, 0);
    go(10'h033, 0, 0, 1, 1, 1, 0);
    expect_act("R10", C_STOP, 0, 0);     stat(8'h38, 0);
    chk("R10", {done, eng_rst, busy, err}, {1'b1, 1'b1, 1'b0, 2'd2});

    // stray status while idle: R11
    expect_act("R11", C_STOP, 0, 0);     stat(8'h28, 0);
    chk("R11", {done, eng_rst, busy}, 3'b000);

    // write abort after one byte: R12
    txm[0] = 8'h01; txm[1] = 8'h02;
    expect_act("R2", C_START, 0, 0);
    go(10'h044, 0, 0, 3, 1, 1, 0);
    expect_act("R4", C_ADDR1, 1, 8'h88); stat(8'h08, 0);
    expect_act("R6", C_WRITE, 1, 8'h01); stat(8'h18, 0);
    tmo();
    chk("R12", {busy, done, err}, {1'b1, 1'b0, 2'd3});
    expect_act("R12", C_STOP, 0, 0);     stat(8'h28, 0);
    chk("R12", {done, err}, {1'b1, 2'd3});

    // read abort drops ack early: R12
    expect_act("R2", C_START, 0, 0);
    go(10'h044, 0, 1, 4, 1, 1, 0);
    expect_act("R4", C_ADDR1, 1, 8'h89); stat(8'h08, 0);
    expect_act("R7", C_CONT, 0, 0);      stat(8'h40, 0);
    chk("R7", {7'd0, ack_en}, 16'h1);
    tmo();
    expect_act("R12", C_READ, 0, 0);     stat(8'h50, 8'h5A);
    chk("R12", {ack_en, rx_valid}, 2'b01);
    expect_act("R8", C_READ_END, 0, 0);  stat(8'h58, 8'h6B);
    chk("R12", {done, rx_data, 6'd0, err}, {1'b1, 8'h6B, 6'd0, 2'd3});

    // double timeout: R13
    expect_act("R2", C_START, 0, 0);
    go(10'h044, 0, 0, 2, 1, 1, 0);
    tmo();
    chk("R12", {busy, done}, 2'b10);
    tmo();
    chk("R13", {done, eng_rst, busy, int_en, err}, {1'b1, 1'b1, 1'b0, 1'b0, 2'd3});

    // 10-bit read: R5 R7 R8
    expect_act("R2", C_START, 0, 0);
    go(10'h3C7, 1, 1, 1, 1, 1, 0);
    expect_act("R3", C_ADDR1, 1, 8'hF7); stat(8'h08, 0);
    expect_act("R5", C_ADDR2, 1, 8'hC7); stat(8'h40, 0);
    expect_act("R7", C_CONT, 0, 0);      stat(8'hE0, 0);
    chk("R7", {7'd0, ack_en}, 16'h0);
    expect_act("R8", C_READ_END, 0, 0);  stat(8'h58, 8'h9E);
    chk("R8", {rx_valid, done, rx_data, 4'd0, err}, {1'b1, 1'b1, 8'h9E, 4'd0, 2'd0});

    // start-less read and write: R14
    expect_act("R14", C_CONT, 0, 0);
    go(10'h000, 0, 1, 1, 0, 1, 1);
    expect_act("R8", C_READ_END, 0, 0);  stat(8'h58, 8'h42);
    chk("R14", {rx_data, 7'd0, done}, {8'h42, 7'd0, 1'b1});
    txm[0] = 8'h77; txm[1] = 8'h88;
    expect_act("R14", C_WRITE, 1, 8'h77);
    go(10'h000, 0, 0, 2, 0, 1, 1);
    expect_act("R6", C_WRITE, 1, 8'h88); stat(8'h28, 0);
    expect_act("R6", C_STOP, 0, 0);      stat(8'h28, 0);
    chk("R14", {done, err}, {1'b1, 2'd0});

    repeat (2) @(negedge clk);
    chk("R2", 16'(expq.size()), 16'd0);
    summary();
  end
endmodule